// File: doc/BRIEF.md
# Data-Memory Address Router with Frame Buffer and Key Port

This block sits between a CPU's data-memory port and three targets that share one 16-bit address space: a general-purpose word store, a frame buffer for a bitmapped display, and a read-only key-code word. The CPU reaches all of them with ordinary loads and stores. The block has no dedicated I/O operations. It decodes each address into a region, raises a write enable only for the region that was addressed, and returns the matching word on a single read bus. An address outside all three regions reads as zero and its writes are dropped.

The decoder always works on the full 16-bit map. General storage occupies `0x0000`-`0x3FFF`. The frame buffer occupies `0x4000`-`0x5FFF`, and each of its words carries 16 adjacent horizontal pixels. The key word sits at `0x6000` alone. Every address from `0x6001` up is unmapped. Two parameters set how many words are actually stored behind the first two regions. If a region is larger than its store, the upper offset bits are not used and offsets wrap inside the region. A display scanner reads the frame buffer through its own combinational port, which is independent of the CPU port. The key word is a register that takes the external key code on every clock edge.

Top module: `memmap_router`

## Requirements
- R1: With `cpu_we` high and `cpu_addr` in `0x0000`-`0x3FFF`, `cpu_wdata` is stored at the rising clock edge. A later combinational read of that address on `cpu_rdata` returns the stored word.
- R2: With `cpu_we` high and `cpu_addr` in `0x4000`-`0x5FFF`, the word is stored in the frame buffer at the rising edge. A combinational read of that address returns it.
- R3: `scan_data` gives combinationally the frame-buffer word at offset `scan_addr`. Offset k holds the word that the CPU wrote at address `0x4000 + k`.
- R4: A read of `0x6000` returns the value `key_code` had at the most recent rising edge. A key code of 0 means no key is held, and the word then reads 0.
- R5: A write to `0x6000` has no effect. The key word, the general store and the frame buffer are all left unchanged.
- R6: Writes to any address from `0x6001` to `0xFFFF` change neither the general store nor the frame buffer.
- R7: A read of any address from `0x6001` to `0xFFFF` returns 0.
- R8: With `cpu_we` low, no target is written, whatever the address and data.
- R9: The regions are isolated from each other. A write to one region leaves the word at the same offset in the other region unchanged.
- R10: Within a region, address bits above the store's index width are ignored. General storage indexes with the low `RAM_AW` bits and the frame buffer with the low `SCR_AW` bits, so offsets wrap modulo the store depth.
- R11: `rst_n` low clears the key word at once, and it then reads 0. The release of reset takes effect two clock edges later, in step with `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores and the key word update on its rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a synchronizer |
| cpu_addr | input | 16 | CPU data address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_we | input | 1 | CPU write request |
| cpu_rdata | output | DATA_W | Combinational read data for `cpu_addr` |
| key_code | input | DATA_W | Code of the key currently held, 0 when none |
| scan_addr | input | SCR_AW | Frame-buffer word offset for the display scanner |
| scan_data | output | DATA_W | Frame-buffer word at `scan_addr` |

## Verification
The bench builds the block with `RAM_AW = 8` and `SCR_AW = 7`, so both stores are far smaller than their regions. With these values, addresses such as `0x0105` or `0x3FFF` alias onto low offsets, which makes the wrap behaviour observable. The top frame-buffer address `0x5FFF` lands on the last scanner offset, so it can be checked there. The unmapped addresses `0x8000` and `0xC003` share their low bits with stored words. Writing to them tests whether the decoder uses the full address or only a partial decode.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  // Width of the CPU data address; the region map is defined over it.
  localparam int unsigned MAP_AW = 16;

  // Region boundaries; the decoder depends on these exact values.
  localparam logic [MAP_AW-1:0] SCR_BASE = 16'h4000;
  localparam logic [MAP_AW-1:0] KEY_ADDR = 16'h6000;

  typedef enum logic [1:0] {
    RGN_RAM  = 2'd0,
    RGN_SCR  = 2'd1,
    RGN_KEY  = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

endpackage

// File: rtl/mm_reset_sync.sv
module mm_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_d;
  logic [STAGES-1:0] sync_q;

  // Shift ones in behind the asynchronous clear.
  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/mm_region_decode.sv
module mm_region_decode
  import memmap_pkg::*;
#(
  parameter int unsigned RAM_AW = 10,  // at most 14
  parameter int unsigned SCR_AW = 9    // at most 13
) (
  input  logic [MAP_AW-1:0] addr,
  input  logic              we,
  output region_e           rgn,
  output logic              we_ram,
  output logic              we_scr,
  output logic [RAM_AW-1:0] ram_idx,
  output logic [SCR_AW-1:0] scr_idx
);

  // Full-address decode: every bit takes part, so nothing above the
  // key word can alias into a mapped region.
  always_comb begin
    if (addr[MAP_AW-1 -: 2] == 2'b00) begin
      rgn = RGN_RAM;
    end else if (addr[MAP_AW-1 -: 3] == 3'b010) begin
      rgn = RGN_SCR;
    end else if (addr == KEY_ADDR) begin
      rgn = RGN_KEY;
    end else begin
      rgn = RGN_NONE;
    end
  end

  always_comb begin
    we_ram = we && (rgn == RGN_RAM);
    we_scr = we && (rgn == RGN_SCR);
  end

  // Offsets inside each region; upper bits beyond the store are dropped.
  assign ram_idx = addr[RAM_AW-1:0];
  assign scr_idx = addr[SCR_AW-1:0];

endmodule

// File: rtl/mm_word_store.sv
module mm_word_store #(
  parameter int unsigned AW  = 8,
  parameter int unsigned DW  = 16,
  parameter int unsigned NRD = 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr [NRD],
  output logic [DW-1:0] rd_data [NRD]
);

  localparam int unsigned DEPTH = 1 << AW;

  // Storage array: contents are not reset.
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  // Independent combinational read ports.
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = mem_q[rd_addr[g]];
  end

endmodule

// File: rtl/mm_key_latch.sv
module mm_key_latch #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] key_in,
  output logic [DW-1:0] key_q
);

  logic [DW-1:0] key_d;

  always_comb begin
    key_d = key_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
    end else begin
      key_q <= key_d;
    end
  end

endmodule

// File: rtl/mm_read_mux.sv
module mm_read_mux
  import memmap_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  region_e       rgn,
  input  logic [DW-1:0] ram_word,
  input  logic [DW-1:0] scr_word,
  input  logic [DW-1:0] key_word,
  output logic [DW-1:0] rdata
);

  always_comb begin
    unique case (rgn)
      RGN_RAM: rdata = ram_word;
      RGN_SCR: rdata = scr_word;
      RGN_KEY: rdata = key_word;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/memmap_router.sv
module memmap_router
  import memmap_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned RAM_AW = 10,
  parameter int unsigned SCR_AW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MAP_AW-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [DATA_W-1:0] key_code,
  input  logic [SCR_AW-1:0] scan_addr,
  output logic [DATA_W-1:0] scan_data
);

  localparam int unsigned RAM_PORTS = 1;
  localparam int unsigned SCR_PORTS = 2;

  logic              rst_q;
  region_e           rgn;
  logic              we_ram;
  logic              we_scr;
  logic [RAM_AW-1:0] ram_idx;
  logic [SCR_AW-1:0] scr_idx;
  logic [DATA_W-1:0] key_q;

  logic [RAM_AW-1:0] ram_raddr [RAM_PORTS];
  logic [DATA_W-1:0] ram_rdata [RAM_PORTS];
  logic [SCR_AW-1:0] scr_raddr [SCR_PORTS];
  logic [DATA_W-1:0] scr_rdata [SCR_PORTS];

  mm_reset_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q)
  );

  mm_region_decode #(.RAM_AW(RAM_AW), .SCR_AW(SCR_AW)) u_dec (
    .addr    (cpu_addr),
    .we      (cpu_we),
    .rgn     (rgn),
    .we_ram  (we_ram),
    .we_scr  (we_scr),
    .ram_idx (ram_idx),
    .scr_idx (scr_idx)
  );

  assign ram_raddr[0] = ram_idx;

  mm_word_store #(.AW(RAM_AW), .DW(DATA_W), .NRD(RAM_PORTS)) u_ram (
    .clk     (clk),
    .wr_en   (we_ram),
    .wr_addr (ram_idx),
    .wr_data (cpu_wdata),
    .rd_addr (ram_raddr),
    .rd_data (ram_rdata)
  );

  // Port 0 serves the CPU, port 1 the display scanner.
  assign scr_raddr[0] = scr_idx;
  assign scr_raddr[1] = scan_addr;

  mm_word_store #(.AW(SCR_AW), .DW(DATA_W), .NRD(SCR_PORTS)) u_scr (
    .clk     (clk),
    .wr_en   (we_scr),
    .wr_addr (scr_idx),
    .wr_data (cpu_wdata),
    .rd_addr (scr_raddr),
    .rd_data (scr_rdata)
  );

  assign scan_data = scr_rdata[1];

  mm_key_latch #(.DW(DATA_W)) u_key (
    .clk    (clk),
    .rst_n  (rst_q),
    .key_in (key_code),
    .key_q  (key_q)
  );

  mm_read_mux #(.DW(DATA_W)) u_mux (
    .rgn      (rgn),
    .ram_word (ram_rdata[0]),
    .scr_word (scr_rdata[0]),
    .key_word (key_q),
    .rdata    (cpu_rdata)
  );

endmodule

// File: rtl/memmap_router_chk.sv
module memmap_router_chk
  import memmap_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_q,
  input logic [MAP_AW-1:0] cpu_addr,
  input logic              cpu_we,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic [DATA_W-1:0] key_code,
  input logic              we_ram,
  input logic              we_scr
);

  // Set once the key word has loaded at least once after reset release.
  logic armed_q;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
    end
  end

  p_ram_we_r1: assert property (@(posedge clk) disable iff (!rst_q)
    we_ram |-> (cpu_we && cpu_addr < SCR_BASE));

  p_scr_we_r2: assert property (@(posedge clk) disable iff (!rst_q)
    we_scr |-> (cpu_we && cpu_addr >= SCR_BASE && cpu_addr < KEY_ADDR));

  p_key_read_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (armed_q && cpu_addr == KEY_ADDR) |-> (cpu_rdata == $past(key_code)));

  p_key_no_write_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (cpu_addr == KEY_ADDR) |-> (!we_ram && !we_scr));

  p_high_no_write_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (cpu_addr > KEY_ADDR) |-> (!we_ram && !we_scr));

  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (cpu_addr > KEY_ADDR) |-> (cpu_rdata == '0));

  p_idle_no_write_r8: assert property (@(posedge clk) disable iff (!rst_q)
    !cpu_we |-> (!we_ram && !we_scr));

  p_one_target_r9: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({we_ram, we_scr}));

endmodule

bind memmap_router memmap_router_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .cpu_addr  (cpu_addr),
  .cpu_we    (cpu_we),
  .cpu_rdata (cpu_rdata),
  .key_code  (key_code),
  .we_ram    (we_ram),
  .we_scr    (we_scr)
);

// File: tb/memmap_router_tb.sv
module memmap_router_tb;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned RAM_AW     = 8;
  localparam int unsigned SCR_AW     = 7;
  localparam int unsigned WATCHDOG   = 20000;

  typedef struct {
    logic              on_scan;
    logic [DATA_W-1:0] exp;
    string             tag;
  } sb_item_t;

  logic              clk;
  logic              rst_n;
  logic [15:0]       cpu_addr;
  logic [DATA_W-1:0] cpu_wdata;
  logic              cpu_we;
  logic [DATA_W-1:0] cpu_rdata;
  logic [DATA_W-1:0] key_code;
  logic [SCR_AW-1:0] scan_addr;
  logic [DATA_W-1:0] scan_data;

  sb_item_t sb_q[$];
  int checks;
  int errors;
  logic done;

  memmap_router #(.DATA_W(DATA_W), .RAM_AW(RAM_AW), .SCR_AW(SCR_AW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_we    (cpu_we),
    .cpu_rdata (cpu_rdata),
    .key_code  (key_code),
    .scan_addr (scan_addr),
    .scan_data (scan_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Monitor: one expected item per cycle, compared away from the edge.
  always @(negedge clk) begin
    if (sb_q.size() != 0) begin
      sb_item_t it;
      logic [DATA_W-1:0] act;
      it = sb_q.pop_front();
      act = it.on_scan ? scan_data : cpu_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [DATA_W-1:0] d);
    @(posedge clk);
    #1;
    cpu_addr  = a;
    cpu_wdata = d;
    cpu_we    = 1'b1;
    @(posedge clk);
    #1;
    cpu_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [DATA_W-1:0] e, input string tag);
    sb_item_t it;
    @(posedge clk);
    #1;
    cpu_addr = a;
    it.on_scan = 1'b0;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic scan(input logic [SCR_AW-1:0] a, input logic [DATA_W-1:0] e, input string tag);
    sb_item_t it;
    @(posedge clk);
    #1;
    scan_addr = a;
    it.on_scan = 1'b1;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  initial begin
    checks    = 0;
    errors    = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    cpu_addr  = 16'h0000;
    cpu_wdata = '0;
    cpu_we    = 1'b0;
    key_code  = 16'h1234;
    scan_addr = '0;

    // R11: key word held at 0 while reset is asserted.
    rd(16'h6000, 16'h0000, "R11 key word in reset");
    @(posedge clk);
    #1;
    rst_n    = 1'b1;
    key_code = 16'h0000;
    repeat (3) @(posedge clk);
    rd(16'h6000, 16'h0000, "R4 no key held");

    // R1 / R10: general store and wrap of its offsets.
    wr(16'h0000, 16'hA5A5);
    wr(16'h00FF, 16'h1111);
    wr(16'h0105, 16'hBEEF);
    rd(16'h0000, 16'hA5A5, "R1 ram word 0");
    rd(16'h00FF, 16'h1111, "R1 ram top offset");
    rd(16'h0005, 16'hBEEF, "R10 ram wrap 0x0105");
    wr(16'h3FFF, 16'h2222);
    rd(16'h00FF, 16'h2222, "R10 ram wrap 0x3FFF");

    // R2 / R3: frame buffer via CPU and scanner ports.
    wr(16'h4000, 16'hFFFF);
    wr(16'h4003, 16'h8001);
    wr(16'h5FFF, 16'h0F0F);
    rd(16'h4003, 16'h8001, "R2 screen word 3");
    rd(16'h5FFF, 16'h0F0F, "R2 screen last address");
    scan(7'd3,  16'h8001, "R3 scan offset 3");
    scan(7'd0,  16'hFFFF, "R3 scan offset 0");
    scan(7'h7F, 16'h0F0F, "R3 scan last offset");

    // R9: isolation between regions at equal offsets.
    rd(16'h0000, 16'hA5A5, "R9 ram untouched by screen write");
    wr(16'h0003, 16'h3333);
    rd(16'h4003, 16'h8001, "R9 screen untouched by ram write");
    rd(16'h0003, 16'h3333, "R9 ram word 3");

    // R4 / R5: key word follows input, ignores writes.
    key_code = 16'h0041;
    rd(16'h6000, 16'h0041, "R4 key held");
    wr(16'h6000, 16'hDEAD);
    rd(16'h6000, 16'h0041, "R5 key word after write");
    rd(16'h0000, 16'hA5A5, "R5 ram after key write");
    scan(7'd0, 16'hFFFF, "R5 screen after key write");

    // R6: writes above the key word land nowhere.
    wr(16'h6001, 16'h7777);
    wr(16'h8000, 16'h7777);
    wr(16'hC003, 16'h7777);
    wr(16'hFFFF, 16'h7777);
    rd(16'h0000, 16'hA5A5, "R6 ram word 0");
    rd(16'h0003, 16'h3333, "R6 ram word 3");
    rd(16'h00FF, 16'h2222, "R6 ram word FF");
    rd(16'h4003, 16'h8001, "R6 screen word 3");
    scan(7'd0,  16'hFFFF, "R6 scan offset 0");
    scan(7'h7F, 16'h0F0F, "R6 scan last offset");

    // R7: unmapped reads return zero.
    rd(16'h6001, 16'h0000, "R7 read 0x6001");
    rd(16'h7FFF, 16'h0000, "R7 read 0x7FFF");
    rd(16'h8000, 16'h0000, "R7 read 0x8000");
    rd(16'hFFFF, 16'h0000, "R7 read 0xFFFF");

    // R8: data presented without write request.
    @(posedge clk);
    #1;
    cpu_addr  = 16'h0000;
    cpu_wdata = 16'h9999;
    @(posedge clk);
    #1;
    cpu_addr  = 16'h4000;
    @(posedge clk);
    rd(16'h0000, 16'hA5A5, "R8 ram with write low");
    scan(7'd0, 16'hFFFF, "R8 screen with write low");

    // R4: key released.
    key_code = 16'h0000;
    rd(16'h6000, 16'h0000, "R4 key released");

    // R11: reset mid-run clears the key word at once.
    key_code = 16'h0041;
    rd(16'h6000, 16'h0041, "R4 key held again");
    @(posedge clk);
    #3;
    rst_n = 1'b0;
    #1;
    checks++;
    if (cpu_rdata !== 16'h0000) begin
      errors++;
      $display("FAIL R11 async clear actual=%h expected=%h", cpu_rdata, 16'h0000);
    end
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    checks++;
    if (cpu_rdata !== 16'h0000) begin
      errors++;
      $display("FAIL R11 release delay actual=%h expected=%h", cpu_rdata, 16'h0000);
    end
    repeat (3) @(posedge clk);
    rd(16'h6000, 16'h0041, "R11 key after release");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL all requirements watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule